// File: doc/BRIEF.md
# Single-Wire Addressable Pixel Chain Encoder

This block drives a chain of single-wire addressable RGB pixels and gives every pixel in the chain the same colour. A 24-bit colour arrives on a valid/ready input. The colour is stored and reordered so that green goes out first, then red, then blue, each byte most significant bit first. Each data bit becomes one fixed slot on a 16 MHz time base, which is derived from the system clock by an integer divider. A 1 is sent as a long high pulse and a 0 as a short one. The same 24-bit word is repeated once per pixel.

After the last pixel the line is held low. First come two empty slots, then a latch gap long enough for the pixels to take the new colour. At the end of the gap the block pulses `done` for one cycle and returns to idle.

Back-pressure is simple. `in_ready` is high only while the block is idle. A colour is taken in the cycle where `in_valid` and `in_ready` are both high. While a frame is in flight, `in_ready` stays low and anything on `in_valid`/`in_rgb` has no effect. `busy` and `done` are plain status pins.

Top module: `pixel_chain_encoder`

## Requirements
- R1: After reset, `dout` is 0, `busy` is 0, `done` is 0 and `in_ready` is 1.
- R2: `in_ready` is 1 exactly when the block is idle. A colour is accepted on a cycle with `in_valid` and `in_ready` both high. `busy` is 1 from the next cycle until the `done` cycle, not including the `done` cycle.
- R3: While busy, `in_valid` and `in_rgb` are ignored: the waveform sent is that of the accepted colour.
- R4: Every bit slot lasts `SLOT_TICKS` (20) ticks, and one tick is `CLK_DIV` system cycles. `dout` rises only at the start of a slot. The first rise is one cycle after the accepting edge.
- R5: A 0 bit is high for `T0H_TICKS` (6) ticks, then low for the rest of its slot.
- R6: A 1 bit is high for `T1H_TICKS` (13) ticks, then low for the rest of its slot.
- R7: Within a pixel, slots 0..7 carry `in_rgb[15:8]` (green), slots 8..15 carry `in_rgb[23:16]` (red) and slots 16..23 carry `in_rgb[7:0]` (blue). Each byte is sent bit 7 first.
- R8: The same 24-slot pattern is sent `N_PIXELS` times in a row, with no gap between pixels.
- R9: `TAIL_SLOTS` (2) slots with zero high time follow the last data bit.
- R10: After the tail, the line stays low for `LATCH_TICKS` ticks (default 800, which is 50 µs at 16 MHz). `done` is then high for exactly one cycle, and the block is idle in that same cycle.
- R11: `dout` is low whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, `CLK_DIV` times the 16 MHz tick rate |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Colour offered |
| in_ready | output | 1 | Block idle and able to take a colour |
| in_rgb | input | 24 | Colour as red[23:16], green[15:8], blue[7:0] |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at the end of the latch gap |
| dout | output | 1 | Serial line to the first pixel |

## Verification
The assertions assume that reset is applied before the first frame. They also assume the timing parameters are consistent: both high widths are shorter than the slot, and there is at least one tail slot and one latch tick. They place no limit on how `in_valid` behaves.

The stimulus deliberately holds `in_valid` high, with an inverted colour on `in_rgb`, through whole frames. This exercises the rule that input is ignored while busy. Valid is dropped one cycle before the expected `done` cycle, so frames are never chained by accident.

The colour sweep covers all-zero, all-one, mixed words and a walking one through each of the 24 bit positions. Every channel position and both bit values therefore reach the line.

// File: rtl/pce_pkg.sv
`timescale 1ns/1ps
package pce_pkg;
  localparam int BITS_PER_PIXEL = 24;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DATA  = 2'd1,
    ST_TAIL  = 2'd2,
    ST_LATCH = 2'd3
  } seq_state_e;

  // Wire order on the line: green, red, blue.
  function automatic logic [23:0] to_wire_order(input logic [23:0] rgb);
    return {rgb[15:8], rgb[23:16], rgb[7:0]};
  endfunction
endpackage

// File: rtl/pce_tick_gen.sv
`timescale 1ns/1ps
module pce_tick_gen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt <= '0;
    else if (restart || cnt == LAST) cnt <= '0;
    else                            cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  // R4
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/pce_slot_shaper.sv
`timescale 1ns/1ps
module pce_slot_shaper #(
  parameter int SLOT_TICKS = 20,
  parameter int HW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          tick,
  input  logic          active,
  input  logic [HW-1:0] high_ticks,
  output logic          slot_end,
  output logic          dout
);
  localparam logic [HW-1:0] PH_LAST = HW'(SLOT_TICKS - 1);

  logic [HW-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n)       phase <= '0;
    else if (restart) phase <= '0;
    else if (tick)    phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
  end

  assign slot_end = tick && (phase == PH_LAST);

  // Registered line driver: glitch-free pin, one cycle behind the phase.
  always_ff @(posedge clk) begin
    if (!rst_n) dout <= 1'b0;
    else        dout <= active && (phase < high_ticks);
  end

  // R4
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= PH_LAST);
  // R4
  rise_at_slot_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout) |-> ($past(phase) == '0));
endmodule

// File: rtl/pce_bit_sequencer.sv
`timescale 1ns/1ps
module pce_bit_sequencer
  import pce_pkg::*;
#(
  parameter int N_PIX = 8,
  parameter int TAIL_SLOTS = 2,
  parameter int LATCH_TICKS = 800,
  parameter int T0H_TICKS = 6,
  parameter int T1H_TICKS = 13,
  parameter int HW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [23:0]   in_rgb,
  input  logic          tick,
  input  logic          slot_end,
  output logic          in_ready,
  output logic          busy,
  output logic          done,
  output logic          restart,
  output logic          active,
  output logic [HW-1:0] high_ticks
);
  localparam int PW = (N_PIX > 1) ? $clog2(N_PIX) : 1;
  localparam int TW = (TAIL_SLOTS > 1) ? $clog2(TAIL_SLOTS) : 1;
  localparam int LW = (LATCH_TICKS > 1) ? $clog2(LATCH_TICKS) : 1;
  localparam logic [PW-1:0] PIX_LAST = PW'(N_PIX - 1);
  localparam logic [TW-1:0] TAIL_LAST = TW'(TAIL_SLOTS - 1);
  localparam logic [LW-1:0] LAT_LAST = LW'(LATCH_TICKS - 1);
  localparam logic [4:0] BIT_LAST = 5'(BITS_PER_PIXEL - 1);
  localparam logic [HW-1:0] W0 = HW'(T0H_TICKS);
  localparam logic [HW-1:0] W1 = HW'(T1H_TICKS);

  seq_state_e    state;
  logic [23:0]   grb_q;
  logic [4:0]    bit_idx;
  logic [PW-1:0] pix_idx;
  logic [TW-1:0] tail_idx;
  logic [LW-1:0] lat_cnt;
  logic          done_q;
  logic          cur_bit;

  assign in_ready = (state == ST_IDLE);
  assign busy     = (state != ST_IDLE);
  assign restart  = in_valid && in_ready;
  assign active   = (state == ST_DATA) || (state == ST_TAIL);
  assign done     = done_q;
  assign cur_bit  = grb_q[BIT_LAST - bit_idx];

  always_comb begin
    if (state == ST_DATA) high_ticks = cur_bit ? W1 : W0;
    else                  high_ticks = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      grb_q    <= '0;
      bit_idx  <= '0;
      pix_idx  <= '0;
      tail_idx <= '0;
      lat_cnt  <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (in_valid) begin
            grb_q   <= to_wire_order(in_rgb);
            bit_idx <= '0;
            pix_idx <= '0;
            state   <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (slot_end) begin
            if (bit_idx == BIT_LAST) begin
              bit_idx <= '0;
              if (pix_idx == PIX_LAST) begin
                tail_idx <= '0;
                state    <= ST_TAIL;
              end else begin
                pix_idx <= pix_idx + 1'b1;
              end
            end else begin
              bit_idx <= bit_idx + 1'b1;
            end
          end
        end
        ST_TAIL: begin
          if (slot_end) begin
            if (tail_idx == TAIL_LAST) begin
              lat_cnt <= '0;
              state   <= ST_LATCH;
            end else begin
              tail_idx <= tail_idx + 1'b1;
            end
          end
        end
        ST_LATCH: begin
          if (tick) begin
            if (lat_cnt == LAT_LAST) begin
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              lat_cnt <= lat_cnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3
  colour_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(grb_q));
  // R10
  done_after_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(state) == ST_LATCH));
  // R8
  pixel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA) |-> (pix_idx <= PIX_LAST && bit_idx <= BIT_LAST));
endmodule

// File: rtl/pixel_chain_encoder.sv
`timescale 1ns/1ps
module pixel_chain_encoder #(
  parameter int N_PIXELS = 8,
  parameter int CLK_DIV = 4,
  parameter int SLOT_TICKS = 20,
  parameter int T0H_TICKS = 6,
  parameter int T1H_TICKS = 13,
  parameter int TAIL_SLOTS = 2,
  parameter int LATCH_TICKS = 800
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [23:0] in_rgb,
  output logic        busy,
  output logic        done,
  output logic        dout
);
  localparam int HW = $clog2(SLOT_TICKS + 1);

  logic          tick;
  logic          restart;
  logic          slot_end;
  logic          active;
  logic [HW-1:0] high_ticks;

  pce_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
  );

  pce_bit_sequencer #(
    .N_PIX(N_PIXELS), .TAIL_SLOTS(TAIL_SLOTS), .LATCH_TICKS(LATCH_TICKS),
    .T0H_TICKS(T0H_TICKS), .T1H_TICKS(T1H_TICKS), .HW(HW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_rgb(in_rgb),
    .tick(tick), .slot_end(slot_end), .in_ready(in_ready), .busy(busy),
    .done(done), .restart(restart), .active(active), .high_ticks(high_ticks)
  );

  pce_slot_shaper #(.SLOT_TICKS(SLOT_TICKS), .HW(HW)) u_shape (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick),
    .active(active), .high_ticks(high_ticks), .slot_end(slot_end), .dout(dout)
  );

  // R11
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !dout);
  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  tail_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && high_ticks == '0) |=> !dout);
endmodule

// File: tb/pixel_chain_encoder_tb.sv
`timescale 1ns/1ps
module pixel_chain_encoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;
  localparam int DIV = 2;
  localparam int SLOT = 20;
  localparam int T0 = 6;
  localparam int T1 = 13;
  localparam int TAIL = 2;
  localparam int LATCH = 40;
  localparam int NSLOT = 24 * NP + TAIL;
  localparam int SLOT_CYC = SLOT * DIV;
  localparam int C_DONE = NSLOT * SLOT_CYC + LATCH * DIV;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [23:0] in_rgb = '0;
  logic in_ready, busy, done, dout;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixel_chain_encoder #(
    .N_PIXELS(NP), .CLK_DIV(DIV), .SLOT_TICKS(SLOT), .T0H_TICKS(T0),
    .T1H_TICKS(T1), .TAIL_SLOTS(TAIL), .LATCH_TICKS(LATCH)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_rgb(in_rgb), .busy(busy), .done(done), .dout(dout)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input logic [23:0] rgb, input bit noisy);
    logic [23:0] wire_word;
    int high_cnt [NSLOT];
    int first_bad;
    string bad_req;
    int bad_act, bad_exp;
    int rises;
    bit rise_ok, busy_ok, ready_ok, prev;
    int done_at, done_cnt;
    wire_word = {rgb[15:8], rgb[23:16], rgb[7:0]};
    foreach (high_cnt[i]) high_cnt[i] = 0;
    first_bad = -1; bad_req = "R5"; bad_act = 0; bad_exp = 0;
    rises = 0; rise_ok = 1; busy_ok = 1; ready_ok = 1; prev = 0;
    done_at = -1; done_cnt = 0;

    @(negedge clk);
    chk(in_ready == 1'b1, "R2", "ready before frame", in_ready, 1);
    in_valid = 1'b1;
    in_rgb = rgb;
    @(posedge clk);
    #1;
    in_valid = noisy;
    in_rgb = ~rgb;
    for (int c = 0; c <= C_DONE + 3; c++) begin
      bit exp_d, exp_busy;
      @(negedge clk);
      exp_d = 1'b0;
      if (c >= 1) begin
        int e, s, tk;
        e = c - 1;
        s = e / SLOT_CYC;
        tk = (e % SLOT_CYC) / DIV;
        if (s < 24 * NP) begin
          bit b;
          b = wire_word[23 - (s % 24)];
          exp_d = (tk < (b ? T1 : T0));
        end
        if (s < NSLOT && dout) high_cnt[s]++;
        if (dout !== exp_d && first_bad < 0) begin
          first_bad = c; bad_act = dout; bad_exp = exp_d;
          if (s >= NSLOT) bad_req = "R10";
          else if (s >= 24 * NP) bad_req = "R9";
          else if (wire_word[23 - (s % 24)]) bad_req = "R6";
          else bad_req = "R5";
        end
        if (dout && !prev && (e % SLOT_CYC) != 0) rise_ok = 0;
      end else if (dout !== 1'b0 && first_bad < 0) begin
        first_bad = c; bad_act = dout; bad_exp = 0; bad_req = "R4";
      end
      if (dout && !prev) rises++;
      prev = dout;
      exp_busy = (c < C_DONE);
      if (busy !== exp_busy) busy_ok = 0;
      if (in_ready !== !exp_busy) ready_ok = 0;
      if (done) begin
        done_cnt++;
        if (done_at < 0) done_at = c;
      end
      if (c == C_DONE - 1) in_valid = 1'b0;
    end

    chk(first_bad < 0, bad_req, $sformatf("line level at cycle %0d", first_bad),
        bad_act, bad_exp);
    chk(rise_ok && rises == 24 * NP, "R4", "rise count / slot alignment", rises, 24 * NP);
    for (int p = 0; p < NP; p++) begin
      logic [23:0] got;
      got = '0;
      for (int k = 0; k < 24; k++)
        got[23 - k] = (high_cnt[p * 24 + k] == T1 * DIV);
      chk(got == wire_word, (p == 0) ? "R7" : "R8",
          $sformatf("decoded word pixel %0d", p), got, wire_word);
    end
    for (int t = 0; t < TAIL; t++)
      chk(high_cnt[24 * NP + t] == 0, "R9", "tail slot high time",
          high_cnt[24 * NP + t], 0);
    chk(busy_ok && ready_ok, "R2", "busy/ready over frame", {busy_ok, ready_ok}, 2'b11);
    chk(done_at == C_DONE && done_cnt == 1, "R10", "done cycle", done_at, C_DONE);
    if (noisy)
      chk(first_bad < 0, "R3", "input while busy ignored", first_bad, -1);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog: actual %0d cycles expected fewer", WATCHDOG);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [23:0] pats [4];
    pats[0] = 24'h000000;
    pats[1] = 24'hFFFFFF;
    pats[2] = 24'hA5C33C;
    pats[3] = 24'h123456;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(dout == 1'b0, "R1", "dout after reset", dout, 0);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    chk(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);
    for (int i = 0; i < 4; i++) run_frame(pats[i], i[0]);
    for (int i = 0; i < 24; i++) run_frame(24'h1 << i, (i % 3) == 0);
    repeat (10) begin
      @(negedge clk);
      // R11 idle line low
      chk(dout == 1'b0 && busy == 1'b0, "R11", "idle line", dout, 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule